// File: doc/BRIEF.md
# Per-Thread Banked Instruction Buffer

This block sits between the fetch-side instruction assembler and the decoder and holds pre-decoded instructions. It keeps one independent FIFO bank per hardware thread. Each bank entry stores up to `SLOTS` instructions that share one base PC. Every stored instruction keeps its own byte offset from that base, its own length, its own start-of-block and end-of-block flags and its raw encoding. An entry may contain the end of one block and the start of the next.

Two sources can write. The first is the normal fetch path. The second is a macro-expansion stream, which injects the child instructions of a template instruction. While the stream is active it owns the write port, and fetch waits. Each cycle, every bank shows its decoder a group of up to `DEC_W` instructions. The group is contiguous in program order and packed from lane 0. It may start part way through the head entry and run on into the entries after it. The decoder takes the whole group by raising that thread's ready. Each thread has its own flush input and its own full/ready signal.

Top module: `ibuf_banked`

## Requirements
- R1: After reset every bank is empty: `bank_ready` is all ones, every `dec_valid` bit is 0, and `fe_ready` is 1 when no expansion is pending.
- R2: An entry accepted with base PC B and N instructions (1 to `SLOTS`) is presented on the decode lanes in slot order. Slot s presents the PC B plus `off[s]` (zero-extended byte offset), together with its own length, its raw instruction and its own flags.
- R3: A bank presents min(`DEC_W`, instructions stored) lanes. The valid lanes are always packed from lane 0 with no gaps, and a group continues from the last instruction of one entry into slot 0 of the next entry.
- R4: While a thread's `dec_ready` is 0, its group is held unchanged. When `dec_ready` is 1 and at least one lane is valid, exactly the presented lanes are removed. The next group then starts with the instruction after the last one taken, even when that is in the middle of an entry.
- R5: Start-of-block and end-of-block flags are returned per instruction exactly as written, including an entry whose slot 1 ends a block and whose slot 2 starts the next.
- R6: Banks are independent. A write, read or flush addressed to one thread leaves the group and the fullness of every other thread unchanged.
- R7: A bank holding `DEPTH` entries drops `bank_ready` for that thread, and a fetch or expansion write aimed at it is refused (its ready is 0) and stores nothing.
- R8: While `xp_active` or `xp_valid` is 1, `fe_ready` is 0 and no fetch write is stored. An expansion write is accepted whenever its target bank is not full. A fetch write held across the stream is stored after the expansion entries.
- R9: A flush of a thread empties its bank at the next clock edge. A write or a read for that thread in the same cycle has no effect.
- R10: A write carrying zero instructions (`*_num` = 0) creates no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | Fetch path offers an entry |
| fe_ready | output | 1 | Fetch entry accepted this cycle if valid |
| fe_tid | input | TID_W | Target thread of the fetch entry |
| fe_base_pc | input | PC_W | Base PC shared by the fetch entry |
| fe_num | input | NUM_W | Number of instructions in the fetch entry, packed from slot 0 |
| fe_off | input | SLOTS x OFF_W | Per-slot byte offset from the base PC |
| fe_len | input | SLOTS x LEN_W | Per-slot instruction length |
| fe_sob | input | SLOTS | Per-slot start-of-block flag |
| fe_eob | input | SLOTS | Per-slot end-of-block flag |
| fe_insn | input | SLOTS x INSN_W | Per-slot raw instruction |
| xp_active | input | 1 | Expansion stream in progress (holds write priority) |
| xp_valid | input | 1 | Expansion stream offers an entry |
| xp_ready | output | 1 | Expansion entry accepted this cycle if valid |
| xp_tid | input | TID_W | Target thread of the expansion entry |
| xp_base_pc | input | PC_W | Base PC of the expansion entry |
| xp_num | input | NUM_W | Instruction count of the expansion entry |
| xp_off | input | SLOTS x OFF_W | Per-slot offsets of the expansion entry |
| xp_len | input | SLOTS x LEN_W | Per-slot lengths of the expansion entry |
| xp_sob | input | SLOTS | Per-slot start-of-block flags of the expansion entry |
| xp_eob | input | SLOTS | Per-slot end-of-block flags of the expansion entry |
| xp_insn | input | SLOTS x INSN_W | Per-slot raw instructions of the expansion entry |
| flush | input | THREADS | Per-thread flush |
| bank_ready | output | THREADS | Per-thread bank has room for one more entry |
| dec_ready | input | THREADS | Per-thread decoder takes the presented group |
| dec_valid | output | THREADS x DEC_W | Per-thread lane valid mask |
| dec_pc | output | THREADS x DEC_W x PC_W | Rebuilt PC per lane |
| dec_len | output | THREADS x DEC_W x LEN_W | Instruction length per lane |
| dec_sob | output | THREADS x DEC_W | Start-of-block flag per lane |
| dec_eob | output | THREADS x DEC_W | End-of-block flag per lane |
| dec_insn | output | THREADS x DEC_W x INSN_W | Raw instruction per lane |

## Verification
The bench targets these cases:
- A read group that begins inside a half-consumed entry and crosses into the next one. A wrong slot pointer repeats or skips instructions, or leaves a gap in the lane mask.
- An entry that straddles a block boundary. Flags kept per entry instead of per instruction smear the start and end marks across the wrong lanes.
- Writes aimed at a full bank, a flush that coincides with a write and a read, and a zero-length write. A design that gets these wrong leaves a ninth entry, a stale group or an empty phantom entry behind.
- A fetch entry held back during an active expansion stream. If fetch is allowed in, its instructions appear ahead of the expansion instructions instead of after them.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  localparam int IB_THREADS = 2;
  localparam int IB_DEC_W   = 4;
  localparam int IB_SLOTS   = 4;
  localparam int IB_DEPTH   = 8;
  localparam int IB_PC_W    = 32;
  localparam int IB_OFF_W   = 4;
  localparam int IB_LEN_W   = 3;
  localparam int IB_INSN_W  = 32;

  // Which source owns the shared write path this cycle
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_FETCH  = 2'd1,
    SRC_EXPAND = 2'd2
  } wr_src_e;
endpackage

// File: rtl/ibuf_wr_arb.sv
module ibuf_wr_arb
  import ibuf_pkg::*;
#(
  parameter int THREADS = IB_THREADS,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fe_valid,
  input  logic [TID_W-1:0]   fe_tid,
  input  logic               xp_active,
  input  logic               xp_valid,
  input  logic [TID_W-1:0]   xp_tid,
  input  logic [THREADS-1:0] bank_ready,
  output logic               fe_ready,
  output logic               xp_ready,
  output wr_src_e            sel,
  output logic [THREADS-1:0] wr_en
);
  logic xp_go, fe_go;

  always_comb begin
    xp_ready = bank_ready[xp_tid];
    // an active expansion stream keeps the port even between its beats
    fe_ready = bank_ready[fe_tid] && !xp_active && !xp_valid;
    xp_go    = xp_valid && xp_ready;
    fe_go    = fe_valid && fe_ready;
    sel      = xp_go ? SRC_EXPAND : (fe_go ? SRC_FETCH : SRC_NONE);
    for (int t = 0; t < THREADS; t++) begin
      wr_en[t] = (xp_go && (xp_tid == TID_W'(t))) ||
                 (fe_go && (fe_tid == TID_W'(t)));
    end
  end

  assert_expand_priority_R8: assert property (@(posedge clk) disable iff (rst)
    (xp_active || xp_valid) |-> (sel != SRC_FETCH));

  assert_one_bank_written_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
endmodule

// File: rtl/ibuf_bank.sv
module ibuf_bank
  import ibuf_pkg::*;
#(
  parameter int DEPTH  = IB_DEPTH,
  parameter int SLOTS  = IB_SLOTS,
  parameter int DEC_W  = IB_DEC_W,
  parameter int PC_W   = IB_PC_W,
  parameter int OFF_W  = IB_OFF_W,
  parameter int LEN_W  = IB_LEN_W,
  parameter int INSN_W = IB_INSN_W,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NUM_W = $clog2(SLOTS + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [PC_W-1:0]              wr_base,
  input  logic [NUM_W-1:0]             wr_num,
  input  logic [SLOTS-1:0][OFF_W-1:0]  wr_off,
  input  logic [SLOTS-1:0][LEN_W-1:0]  wr_len,
  input  logic [SLOTS-1:0]             wr_sob,
  input  logic [SLOTS-1:0]             wr_eob,
  input  logic [SLOTS-1:0][INSN_W-1:0] wr_insn,
  input  logic                         rd_ack,
  output logic                         ready,
  output logic [DEC_W-1:0]             out_valid,
  output logic [DEC_W-1:0][PC_W-1:0]   out_pc,
  output logic [DEC_W-1:0][LEN_W-1:0]  out_len,
  output logic [DEC_W-1:0]             out_sob,
  output logic [DEC_W-1:0]             out_eob,
  output logic [DEC_W-1:0][INSN_W-1:0] out_insn
);
  // entry storage, no reset so it maps onto RAM
  logic [PC_W-1:0]   base_q [DEPTH];
  logic [NUM_W-1:0]  num_q  [DEPTH];
  logic [OFF_W-1:0]  off_q  [DEPTH][SLOTS];
  logic [LEN_W-1:0]  len_q  [DEPTH][SLOTS];
  logic              sob_q  [DEPTH][SLOTS];
  logic              eob_q  [DEPTH][SLOTS];
  logic [INSN_W-1:0] insn_q [DEPTH][SLOTS];

  logic [AW-1:0] head_q, tail_q, nxt_head;
  logic [SW-1:0] sp_q, nxt_sp;
  logic [CW-1:0] cnt_q, popped;
  logic          push, pop;

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign ready = (cnt_q < CW'(DEPTH));
  assign push  = wr_en && ready && (wr_num != '0) && !flush;
  assign pop   = rd_ack && out_valid[0] && !flush;

  // group assembly: walk from the head slot pointer across entries
  always_comb begin
    logic [AW-1:0] e;
    logic [SW-1:0] s;
    logic [CW-1:0] left;
    e = head_q;
    s = sp_q;
    left = cnt_q;
    out_valid = '0;
    out_pc    = '0;
    out_len   = '0;
    out_sob   = '0;
    out_eob   = '0;
    out_insn  = '0;
    for (int l = 0; l < DEC_W; l++) begin
      if (left != '0) begin
        out_valid[l] = 1'b1;
        out_pc[l]    = base_q[e] + PC_W'(off_q[e][s]);
        out_len[l]   = len_q[e][s];
        out_sob[l]   = sob_q[e][s];
        out_eob[l]   = eob_q[e][s];
        out_insn[l]  = insn_q[e][s];
        if (int'(s) + 1 == int'(num_q[e])) begin
          e    = inc_ptr(e);
          s    = '0;
          left = left - 1'b1;
        end else begin
          s = s + 1'b1;
        end
      end
    end
    nxt_head = e;
    nxt_sp   = s;
    popped   = cnt_q - left;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q <= '0;
      tail_q <= '0;
      sp_q   <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= inc_ptr(tail_q);
      if (pop) begin
        head_q <= nxt_head;
        sp_q   <= nxt_sp;
      end
      cnt_q <= cnt_q + CW'(push) - (pop ? popped : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      base_q[tail_q] <= wr_base;
      num_q[tail_q]  <= wr_num;
      for (int s = 0; s < SLOTS; s++) begin
        off_q[tail_q][s]  <= wr_off[s];
        len_q[tail_q][s]  <= wr_len[s];
        sob_q[tail_q][s]  <= wr_sob[s];
        eob_q[tail_q][s]  <= wr_eob[s];
        insn_q[tail_q][s] <= wr_insn[s];
      end
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ready);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0) && !out_valid[0]);

  assert_lanes_packed_R3: assert property (@(posedge clk) disable iff (rst)
    ((out_valid & (out_valid + 1'b1)) == '0));

  assert_stored_visible_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> out_valid[0]);

  assert_pop_advances_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && out_valid[0] && !flush && !wr_en) |=>
      ((head_q != $past(head_q)) || (sp_q != $past(sp_q))));
endmodule

// File: rtl/ibuf_banked.sv
module ibuf_banked
  import ibuf_pkg::*;
#(
  parameter int THREADS = IB_THREADS,
  parameter int DEC_W   = IB_DEC_W,
  parameter int SLOTS   = IB_SLOTS,
  parameter int DEPTH   = IB_DEPTH,
  parameter int PC_W    = IB_PC_W,
  parameter int OFF_W   = IB_OFF_W,
  parameter int LEN_W   = IB_LEN_W,
  parameter int INSN_W  = IB_INSN_W,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int NUM_W  = $clog2(SLOTS + 1)
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     fe_valid,
  output logic                                     fe_ready,
  input  logic [TID_W-1:0]                         fe_tid,
  input  logic [PC_W-1:0]                          fe_base_pc,
  input  logic [NUM_W-1:0]                         fe_num,
  input  logic [SLOTS-1:0][OFF_W-1:0]              fe_off,
  input  logic [SLOTS-1:0][LEN_W-1:0]              fe_len,
  input  logic [SLOTS-1:0]                         fe_sob,
  input  logic [SLOTS-1:0]                         fe_eob,
  input  logic [SLOTS-1:0][INSN_W-1:0]             fe_insn,
  input  logic                                     xp_active,
  input  logic                                     xp_valid,
  output logic                                     xp_ready,
  input  logic [TID_W-1:0]                         xp_tid,
  input  logic [PC_W-1:0]                          xp_base_pc,
  input  logic [NUM_W-1:0]                         xp_num,
  input  logic [SLOTS-1:0][OFF_W-1:0]              xp_off,
  input  logic [SLOTS-1:0][LEN_W-1:0]              xp_len,
  input  logic [SLOTS-1:0]                         xp_sob,
  input  logic [SLOTS-1:0]                         xp_eob,
  input  logic [SLOTS-1:0][INSN_W-1:0]             xp_insn,
  input  logic [THREADS-1:0]                       flush,
  output logic [THREADS-1:0]                       bank_ready,
  input  logic [THREADS-1:0]                       dec_ready,
  output logic [THREADS-1:0][DEC_W-1:0]            dec_valid,
  output logic [THREADS-1:0][DEC_W-1:0][PC_W-1:0]  dec_pc,
  output logic [THREADS-1:0][DEC_W-1:0][LEN_W-1:0] dec_len,
  output logic [THREADS-1:0][DEC_W-1:0]            dec_sob,
  output logic [THREADS-1:0][DEC_W-1:0]            dec_eob,
  output logic [THREADS-1:0][DEC_W-1:0][INSN_W-1:0] dec_insn
);
  wr_src_e                      sel;
  logic [THREADS-1:0]           wr_en;
  logic [PC_W-1:0]              w_base;
  logic [NUM_W-1:0]             w_num;
  logic [SLOTS-1:0][OFF_W-1:0]  w_off;
  logic [SLOTS-1:0][LEN_W-1:0]  w_len;
  logic [SLOTS-1:0]             w_sob, w_eob;
  logic [SLOTS-1:0][INSN_W-1:0] w_insn;

  ibuf_wr_arb #(.THREADS(THREADS)) i_arb (
    .clk(clk), .rst(rst),
    .fe_valid(fe_valid), .fe_tid(fe_tid),
    .xp_active(xp_active), .xp_valid(xp_valid), .xp_tid(xp_tid),
    .bank_ready(bank_ready),
    .fe_ready(fe_ready), .xp_ready(xp_ready),
    .sel(sel), .wr_en(wr_en)
  );

  always_comb begin
    if (sel == SRC_EXPAND) begin
      w_base = xp_base_pc; w_num = xp_num; w_off = xp_off;
      w_len  = xp_len;     w_sob = xp_sob; w_eob = xp_eob; w_insn = xp_insn;
    end else begin
      w_base = fe_base_pc; w_num = fe_num; w_off = fe_off;
      w_len  = fe_len;     w_sob = fe_sob; w_eob = fe_eob; w_insn = fe_insn;
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_bank
    ibuf_bank #(
      .DEPTH(DEPTH), .SLOTS(SLOTS), .DEC_W(DEC_W), .PC_W(PC_W),
      .OFF_W(OFF_W), .LEN_W(LEN_W), .INSN_W(INSN_W)
    ) i_bank (
      .clk(clk), .rst(rst), .flush(flush[t]),
      .wr_en(wr_en[t]), .wr_base(w_base), .wr_num(w_num),
      .wr_off(w_off), .wr_len(w_len), .wr_sob(w_sob), .wr_eob(w_eob),
      .wr_insn(w_insn),
      .rd_ack(dec_ready[t]), .ready(bank_ready[t]),
      .out_valid(dec_valid[t]), .out_pc(dec_pc[t]), .out_len(dec_len[t]),
      .out_sob(dec_sob[t]), .out_eob(dec_eob[t]), .out_insn(dec_insn[t])
    );
  end
endmodule

// File: tb/test_ibuf_banked.sv
`timescale 1ns/1ps
module test_ibuf_banked;
  localparam int T = 2, DW = 4, SL = 4, DP = 8;

  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic fe_valid, fe_ready, xp_active, xp_valid, xp_ready;
  logic [0:0] fe_tid, xp_tid;
  logic [31:0] fe_base_pc, xp_base_pc;
  logic [2:0] fe_num, xp_num;
  logic [SL-1:0][3:0] fe_off, xp_off;
  logic [SL-1:0][2:0] fe_len, xp_len;
  logic [SL-1:0] fe_sob, fe_eob, xp_sob, xp_eob;
  logic [SL-1:0][31:0] fe_insn, xp_insn;
  logic [T-1:0] flush, bank_ready, dec_ready;
  logic [T-1:0][DW-1:0] dec_valid, dec_sob, dec_eob;
  logic [T-1:0][DW-1:0][31:0] dec_pc, dec_insn;
  logic [T-1:0][DW-1:0][2:0] dec_len;

  ibuf_banked i_ibuf_banked (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one entry on a source: offsets 2*s, length s+1, tagged payload
  task automatic drive(input bit xp, input int tid, input logic [31:0] base, input int n,
                       input logic [3:0] sob, input logic [3:0] eob, input logic [3:0] tag);
    for (int s = 0; s < SL; s++) begin
      if (xp) begin
        xp_off[s] = 4'(2*s); xp_len[s] = 3'(s+1); xp_insn[s] = {base[23:0], tag, 4'(s)};
      end else begin
        fe_off[s] = 4'(2*s); fe_len[s] = 3'(s+1); fe_insn[s] = {base[23:0], tag, 4'(s)};
      end
    end
    if (xp) begin
      xp_valid = 1; xp_tid = 1'(tid); xp_base_pc = base; xp_num = 3'(n); xp_sob = sob; xp_eob = eob;
    end else begin
      fe_valid = 1; fe_tid = 1'(tid); fe_base_pc = base; fe_num = 3'(n); fe_sob = sob; fe_eob = eob;
    end
  endtask

  task automatic put(input int tid, input logic [31:0] base, input int n, input logic [3:0] tag);
    @(negedge clk); drive(0, tid, base, n, 4'b0, 4'b0, tag);
    @(negedge clk); fe_valid = 0;
  endtask

  task automatic pop(input int tid);
    @(negedge clk); dec_ready[tid] = 1;
    @(negedge clk); dec_ready[tid] = 0;
  endtask

  // stimulus rows for thread 0: {base, count, sob mask, eob mask}
  localparam logic [42:0] ROWS [6] = '{
    {32'h1000, 3'd3, 4'b0001, 4'b0000},
    {32'h1100, 3'd1, 4'b0000, 4'b0001},
    {32'h1200, 3'd4, 4'b0100, 4'b0010},
    {32'h1300, 3'd2, 4'b0000, 4'b0000},
    {32'h1400, 3'd4, 4'b0001, 4'b1000},
    {32'h1500, 3'd1, 4'b0001, 4'b0001}
  };

  logic [31:0] e_pc [16];
  logic [31:0] e_insn [16];
  logic [2:0]  e_len [16];
  logic        e_sob [16], e_eob [16];
  int total;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; fe_valid = 0; xp_valid = 0; xp_active = 0; flush = 0; dec_ready = 0;
    fe_tid = 0; xp_tid = 0; fe_base_pc = 0; xp_base_pc = 0; fe_num = 0; xp_num = 0;
    fe_off = '0; xp_off = '0; fe_len = '0; xp_len = '0; fe_sob = 0; fe_eob = 0;
    xp_sob = 0; xp_eob = 0; fe_insn = '0; xp_insn = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 bank_ready", 64'(bank_ready), 64'h3);
    check("R1 dec_valid t0", 64'(dec_valid[0]), 0);
    check("R1 dec_valid t1", 64'(dec_valid[1]), 0);
    check("R1 fe_ready", 64'(fe_ready), 1);

    // table walk: write rows and build the expected instruction list
    total = 0;
    for (int r = 0; r < 6; r++) begin
      logic [31:0] b; int n; logic [3:0] so, eo;
      b = ROWS[r][42:11]; n = int'(ROWS[r][10:8]); so = ROWS[r][7:4]; eo = ROWS[r][3:0];
      @(negedge clk);
      drive(0, 0, b, n, so, eo, 4'(r));
      #1 check("R7 fe_ready while not full", 64'(fe_ready), 1);
      for (int s = 0; s < n; s++) begin
        e_pc[total] = b + 32'(2*s); e_len[total] = 3'(s+1);
        e_sob[total] = so[s]; e_eob[total] = eo[s];
        e_insn[total] = {b[23:0], 4'(r), 4'(s)};
        total++;
      end
    end
    @(negedge clk); fe_valid = 0;
    put(1, 32'h2000, 2, 4'h9);

    // hold: group stays while dec_ready is low (R4)
    @(negedge clk);
    check("R4 hold valid", 64'(dec_valid[0]), 64'hF);
    @(negedge clk);
    check("R4 hold pc", 64'(dec_pc[0][3]), 64'(e_pc[3]));

    // drain thread 0 group by group (R2, R3, R4, R5)
    for (int g = 0; g * DW < total; g++) begin
      int k;
      k = (total - g*DW > DW) ? DW : total - g*DW;
      @(negedge clk);
      dec_ready[0] = 0;
      #1;
      check("R3 lane mask", 64'(dec_valid[0]), 64'((1 << k) - 1));
      for (int l = 0; l < k; l++) begin
        check("R2 pc", 64'(dec_pc[0][l]), 64'(e_pc[g*DW+l]));
        check("R2 len", 64'(dec_len[0][l]), 64'(e_len[g*DW+l]));
        check("R2 insn", 64'(dec_insn[0][l]), 64'(e_insn[g*DW+l]));
        check("R5 sob", 64'(dec_sob[0][l]), 64'(e_sob[g*DW+l]));
        check("R5 eob", 64'(dec_eob[0][l]), 64'(e_eob[g*DW+l]));
      end
      check("R6 other thread untouched", 64'(dec_valid[1]), 64'h3);
      dec_ready[0] = 1;
    end
    @(negedge clk); dec_ready[0] = 0;
    check("R4 drained empty", 64'(dec_valid[0]), 0);
    check("R6 t1 pc lane1", 64'(dec_pc[1][1]), 64'h2002);

    // flush thread 1 only
    @(negedge clk); flush[1] = 1;
    @(negedge clk); flush[1] = 0;
    check("R9 flush t1 empties", 64'(dec_valid[1]), 0);
    check("R9 flush t1 ready", 64'(bank_ready), 64'h3);

    // fill thread 0, then try a ninth entry (R7)
    for (int i = 0; i < DP; i++) put(0, 32'h3000 + 32'(16*i), 1, 4'(i));
    @(negedge clk);
    check("R7 bank_ready when full", 64'(bank_ready), 64'h2);
    drive(0, 0, 32'h3800, 1, 0, 0, 4'hF);
    #1 check("R7 fe_ready full", 64'(fe_ready), 0);
    @(negedge clk); fe_valid = 0;
    check("R7 head pc", 64'(dec_pc[0][0]), 64'h3000);
    pop(0);
    check("R7 second group pc", 64'(dec_pc[0][3]), 64'h3070);
    pop(0);
    check("R7 ninth not stored", 64'(dec_valid[0]), 0);

    // flush with a same-cycle write and read (R9)
    put(0, 32'h3900, 2, 4'h1);
    @(negedge clk);
    flush[0] = 1; dec_ready[0] = 1;
    drive(0, 0, 32'h3A00, 3, 0, 0, 4'h2);
    @(negedge clk);
    flush[0] = 0; dec_ready[0] = 0; fe_valid = 0;
    check("R9 flush beats write", 64'(dec_valid[0]), 0);

    // expansion priority (R8)
    @(negedge clk);
    xp_active = 1;
    drive(0, 0, 32'h4000, 1, 0, 0, 4'h4);
    #1 check("R8 fetch blocked", 64'(fe_ready), 0);
    @(negedge clk);
    check("R8 fetch not stored", 64'(dec_valid[0]), 0);
    drive(1, 0, 32'h5000, 3, 4'b0001, 4'b0000, 4'h5);
    #1 check("R8 xp_ready", 64'(xp_ready), 1);
    check("R8 fe_ready during beat", 64'(fe_ready), 0);
    @(negedge clk);
    xp_valid = 0; xp_active = 0;
    check("R8 expansion first", 64'(dec_pc[0][0]), 64'h5000);
    check("R8 only expansion", 64'(dec_valid[0]), 64'h7);
    @(negedge clk);
    fe_valid = 0;
    check("R8 fetch after stream", 64'(dec_pc[0][3]), 64'h4000);
    check("R3 span into next entry", 64'(dec_valid[0]), 64'hF);

    // zero-length write (R10)
    @(negedge clk); flush[0] = 1;
    @(negedge clk); flush[0] = 0;
    drive(0, 0, 32'h6000, 0, 0, 0, 4'h6);
    @(negedge clk); fe_valid = 0;
    check("R10 zero write dropped", 64'(dec_valid[0]), 0);
    put(0, 32'h6100, 1, 4'h7);
    @(negedge clk);
    check("R10 next write at head", 64'(dec_pc[0][0]), 64'h6100);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule